// File: doc/BRIEF.md
# Burst-Mode Radix-2 FFT Engine

This block computes an N-point forward discrete Fourier transform of complex fixed-point samples with the least hardware it can. One radix-2 decimation-in-time butterfly is shared by every stage and every butterfly position. One register-based working memory holds the frame between stages. The twiddle factors come from a quarter-wave sine table that is computed at elaboration. The transform length is a power-of-two parameter from 8 to 65536.

The engine runs one frame at a time in three phases. First it reads N samples, one per clock. Then it runs log2(N) in-place stages of N/2 butterflies each. Last it plays the N bins out, one per clock, in natural order. A start/ready/dvalid handshake frames this sequence. Upstream logic pulses or holds `start` while `ready` is high, feeds samples on the following N clocks, and collects results while `dvalid` is high. Each incoming sample is stored at the bit-reversed address of its index. Because of this, the in-place stages leave bin k at address k.

Butterfly outputs keep full gain: no stage divides by two. Twiddle products are rescaled by floor or round-to-nearest. Sums are saturated or wrapped to the data width, as the parameters select.

Top module: `fft_burst_r2`

## Requirements
- R1: One clock after synchronous reset is released, `ready` is 1 and `dvalid` is 0.
- R2: When `start` is 1 in a clock where `ready` is 1, a frame is accepted and `ready` is 0 from the next clock. While `ready` is 0, `start` has no effect, whatever its level or duration: exactly one frame runs, with unchanged timing.
- R3: Sample i (i = 0..N-1) is taken from `din_re`/`din_im` at the (i+1)-th rising edge after the accepting edge. Input values at any other time have no effect on the results.
- R4: `dvalid` is 1 for exactly N consecutive clocks. The first of these clocks follows the accepting edge by N + log2(N)·N/2 + 1 edges, and `dvalid` is never 1 while `ready` is 1.
- R5: In the k-th clock of the burst (k = 0..N-1), `dout_re`/`dout_im` carry bin k of the unscaled forward transform X[k] = Σ x[n]·e^(−j2πnk/N), within a small rounding error when no saturation occurs.
- R6: `ready` returns to 1 in the clock right after the last `dvalid` clock. The whole frame, from the accepting edge to the edge that raises `ready`, lasts 2N + log2(N)·N/2 + 1 edges.
- R7: With saturation selected (the default), a result above the signed data range is clamped to 2^(DW−1)−1, and a result below it to −2^(DW−1).
- R8: An input whose only nonzero sample is at index 0 gives exactly that sample value in every bin, with no rounding error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame request, honoured only while ready is high |
| din_re | input | DW | Real part of the serial input sample, two's complement |
| din_im | input | DW | Imaginary part of the serial input sample |
| ready | output | 1 | High while idle and able to accept a frame |
| dvalid | output | 1 | High while an output bin is present on dout |
| dout_re | output | DW | Real part of the current output bin |
| dout_im | output | DW | Imaginary part of the current output bin |

## Verification
The bound checker watches the handshake on every clock. It checks that the burst never exceeds N and ends at exactly N. It checks that `ready` falls after acceptance, stays low until right after the burst, and is never high together with `dvalid`. It checks that the low span of `ready` equals the frame length. The arithmetic can only be shown by the bench scenarios, which compare every bin against a transform computed from the inputs. These scenarios cover an exact impulse, shifted impulses, a tone, mixed data and clamped constants. The bench also drives junk outside the load window and holds `start` through a whole frame, to show that both have no effect.

// File: rtl/fft_r2_pkg.sv
package fft_r2_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CALC,
        ST_SEND
    } fft_state_e;

    typedef enum logic {
        RND_FLOOR,
        RND_NEAREST
    } rnd_mode_e;

    typedef enum logic {
        OVF_SAT,
        OVF_WRAP
    } ovf_mode_e;

    // Edges from the accepting edge to the edge that raises ready again.
    function automatic int unsigned fft_frame_clocks(input int unsigned n);
        int unsigned l;
        l = $clog2(n);
        return 2 * n + l * (n / 2) + 1;
    endfunction

endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
    parameter int N  = 8,
    parameter int TW = 16,
    localparam int KW = $clog2(N) - 1
) (
    input  logic [KW-1:0]        k,
    output logic signed [TW-1:0] cos_o,
    output logic signed [TW-1:0] sin_o
);
    localparam int Q   = N / 4;
    localparam int CAP = (1 << (TW - 1)) - 1;

    logic signed [TW-1:0] qtab [N/2];

    // Quarter-wave sine, fraction TW-1, rounded to nearest and clamped.
    for (genvar i = 0; i < N / 2; i++) begin : g_q
        if (i <= Q) begin : g_used
            localparam real ANG = 6.283185307179586 * i / N;
            localparam real SCL = 2.0 ** (TW - 1);
            localparam int  RAW = $rtoi($sin(ANG) * SCL + 0.5);
            assign qtab[i] = (RAW > CAP) ? TW'(CAP) : TW'(RAW);
        end else begin : g_pad
            assign qtab[i] = '0;
        end
    end

    always_comb begin
        if (k <= KW'(Q)) begin
            sin_o = qtab[k];
            cos_o = qtab[KW'(Q) - k];
        end else begin
            sin_o = qtab[KW'(0) - k];
            cos_o = -qtab[k - KW'(Q)];
        end
    end

endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen #(
    parameter int N = 8,
    localparam int L  = $clog2(N),
    localparam int KW = L - 1,
    localparam int SW = $clog2(L)
) (
    input  logic [SW-1:0] stage,
    input  logic [KW-1:0] idx,
    output logic [L-1:0]  a_addr,
    output logic [L-1:0]  b_addr,
    output logic [KW-1:0] tw_k
);
    always_comb begin
        int unsigned s;
        logic [L-1:0] ix;
        logic [L-1:0] grp;
        logic [L-1:0] pos;
        s      = 32'(stage);
        ix     = {1'b0, idx};
        pos    = ix & L'((32'd1 << s) - 32'd1);
        grp    = ix >> s;
        a_addr = (grp << (s + 1)) | pos;
        b_addr = a_addr | L'(32'd1 << s);
        tw_k   = KW'(pos << (KW - s));
    end

endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly
    import fft_r2_pkg::*;
#(
    parameter int        DW  = 16,
    parameter int        TW  = 16,
    parameter rnd_mode_e RND = RND_FLOOR,
    parameter ovf_mode_e OVF = OVF_SAT
) (
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [TW-1:0] w_cos,
    input  logic signed [TW-1:0] w_sin,
    output logic signed [DW-1:0] x_re,
    output logic signed [DW-1:0] x_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    localparam int PW = DW + TW;
    localparam logic signed [PW:0] BIAS =
        (RND == RND_NEAREST) ? (PW+1)'(1) <<< (TW - 2) : '0;
    localparam logic signed [PW+1:0] HI = {{(PW+3-DW){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW+1:0] LO = {{(PW+3-DW){1'b1}}, {(DW-1){1'b0}}};

    function automatic logic signed [DW-1:0] fit(input logic signed [PW+1:0] v);
        if (OVF == OVF_SAT && v > HI) return HI[DW-1:0];
        if (OVF == OVF_SAT && v < LO) return LO[DW-1:0];
        return v[DW-1:0];
    endfunction

    logic signed [PW-1:0] p_rc, p_is, p_ic, p_rs;
    logic signed [PW:0]   t_re_w, t_im_w, t_re, t_im;

    always_comb begin
        // b * (cos - j sin): four real products, two sums
        p_rc   = PW'(b_re) * PW'(w_cos);
        p_is   = PW'(b_im) * PW'(w_sin);
        p_ic   = PW'(b_im) * PW'(w_cos);
        p_rs   = PW'(b_re) * PW'(w_sin);
        t_re_w = (PW+1)'(p_rc) + (PW+1)'(p_is);
        t_im_w = (PW+1)'(p_ic) - (PW+1)'(p_rs);
        t_re   = (t_re_w + BIAS) >>> (TW - 1);
        t_im   = (t_im_w + BIAS) >>> (TW - 1);
        x_re   = fit((PW+2)'(a_re) + (PW+2)'(t_re));
        x_im   = fit((PW+2)'(a_im) + (PW+2)'(t_im));
        y_re   = fit((PW+2)'(a_re) - (PW+2)'(t_re));
        y_im   = fit((PW+2)'(a_im) - (PW+2)'(t_im));
    end

endmodule

// File: rtl/fft_burst_r2.sv
module fft_burst_r2
    import fft_r2_pkg::*;
#(
    parameter int        N   = 8,
    parameter int        DW  = 16,
    parameter int        TW  = DW,
    parameter rnd_mode_e RND = RND_FLOOR,
    parameter ovf_mode_e OVF = OVF_SAT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic signed [DW-1:0] din_re,
    input  logic signed [DW-1:0] din_im,
    output logic                 ready,
    output logic                 dvalid,
    output logic signed [DW-1:0] dout_re,
    output logic signed [DW-1:0] dout_im
);
    localparam int L  = $clog2(N);
    localparam int KW = L - 1;
    localparam int SW = $clog2(L);

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cplx_t;

    fft_state_e state;
    logic [L-1:0]  cnt;
    logic [KW-1:0] idx;
    logic [SW-1:0] stage;
    logic [L-1:0]  wr_rev;
    logic [L-1:0]  a_addr, b_addr;
    logic [KW-1:0] tw_k;
    logic signed [TW-1:0] w_cos, w_sin;
    cplx_t mem [N];
    cplx_t op_a, op_b, bf_x, bf_y, rd_out;

    // Control sequence: idle -> load N -> L stages of N/2 -> send N
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            stage <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) state <= ST_LOAD;
                end
                ST_LOAD: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == L'(N - 1)) begin
                        state <= ST_CALC;
                        idx   <= '0;
                        stage <= '0;
                    end
                end
                ST_CALC: begin
                    idx <= idx + 1'b1;
                    if (idx == KW'(N / 2 - 1)) begin
                        if (stage == SW'(L - 1)) begin
                            state <= ST_SEND;
                            cnt   <= '0;
                        end else begin
                            stage <= stage + 1'b1;
                        end
                    end
                end
                ST_SEND: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == L'(N - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        for (int i = 0; i < L; i++) wr_rev[i] = cnt[L-1-i];
    end

    fft_addr_gen #(.N(N)) u_addr (
        .stage  (stage),
        .idx    (idx),
        .a_addr (a_addr),
        .b_addr (b_addr),
        .tw_k   (tw_k)
    );

    fft_twiddle_rom #(.N(N), .TW(TW)) u_rom (
        .k     (tw_k),
        .cos_o (w_cos),
        .sin_o (w_sin)
    );

    assign op_a   = mem[a_addr];
    assign op_b   = mem[b_addr];
    assign rd_out = mem[cnt];

    fft_butterfly #(.DW(DW), .TW(TW), .RND(RND), .OVF(OVF)) u_bfly (
        .a_re  (op_a.re),
        .a_im  (op_a.im),
        .b_re  (op_b.re),
        .b_im  (op_b.im),
        .w_cos (w_cos),
        .w_sin (w_sin),
        .x_re  (bf_x.re),
        .x_im  (bf_x.im),
        .y_re  (bf_y.re),
        .y_im  (bf_y.im)
    );

    // Working memory: bit-reversed fill, then in-place butterflies
    always_ff @(posedge clk) begin
        if (state == ST_LOAD) begin
            mem[wr_rev] <= '{re: din_re, im: din_im};
        end else if (state == ST_CALC) begin
            mem[a_addr] <= bf_x;
            mem[b_addr] <= bf_y;
        end
    end

    assign ready   = (state == ST_IDLE);
    assign dvalid  = (state == ST_SEND);
    assign dout_re = rd_out.re;
    assign dout_im = rd_out.im;

endmodule

// File: rtl/fft_burst_r2_chk.sv
module fft_burst_r2_chk
    import fft_r2_pkg::*;
#(
    parameter int N = 8
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic ready,
    input logic dvalid
);
    localparam int unsigned FRAME = fft_frame_clocks(N);

    int unsigned run_len;
    int unsigned low_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= 0;
            low_len <= 0;
        end else begin
            run_len <= dvalid ? run_len + 1 : 0;
            low_len <= ready ? 0 : low_len + 1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ready && !dvalid));

    // R2
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> !ready);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && !dvalid) |=> !ready);

    // R4
    burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
        dvalid |-> (run_len < N));

    // R4
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dvalid) |-> (run_len == N));

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> !dvalid);

    // R6
    ready_return_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dvalid) |-> ready);

    // R6
    frame_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (low_len == FRAME - 1));

    // R2
    start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !ready && !$past(ready)) |=> $stable(ready) || $past(dvalid));

endmodule

bind fft_burst_r2 fft_burst_r2_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .ready  (ready),
    .dvalid (dvalid)
);

// File: tb/fft_burst_r2_bench.sv
module fft_burst_r2_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int DW  = 16;
    localparam int L   = $clog2(N);
    localparam int C   = L * N / 2;
    localparam int TOL = 8;
    localparam real TWO_PI = 6.283185307179586;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic signed [DW-1:0] din_re = '0;
    logic signed [DW-1:0] din_im = '0;
    logic ready, dvalid;
    logic signed [DW-1:0] dout_re, dout_im;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int in_re [N];
    int in_im [N];
    int out_re [N];
    int out_im [N];
    int first_dv, dv_count, ready_bad, ready_end;

    always #(CLK_PERIOD/2) clk = ~clk;

    fft_burst_r2 #(.N(N), .DW(DW)) u_fft_burst_r2 (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .din_re  (din_re),
        .din_im  (din_im),
        .ready   (ready),
        .dvalid  (dvalid),
        .dout_re (dout_re),
        .dout_im (dout_im)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One frame; hold keeps start high through the busy span.
    task automatic run_frame(input bit hold);
        first_dv = -1; dv_count = 0; ready_bad = 0; ready_end = 0;
        @(negedge clk);
        check(ready == 1'b1, "R2", "ready before start", int'(ready), 1);
        start = 1'b1;
        @(posedge clk);
        for (int m = 1; m <= 2 * N + C + 1; m++) begin
            @(negedge clk);
            if (!hold || m == 2 * N + C) start = 1'b0;
            if (dvalid) begin
                if (first_dv < 0) first_dv = m;
                if (dv_count < N) begin
                    out_re[dv_count] = int'(dout_re);
                    out_im[dv_count] = int'(dout_im);
                end
                dv_count++;
            end
            if (m <= 2 * N + C && ready) ready_bad++;
            if (m == 2 * N + C + 1) ready_end = int'(ready);
            if (m <= N) begin
                din_re = DW'(in_re[m-1]);
                din_im = DW'(in_im[m-1]);
            end else begin
                din_re = 16'sh5a5a;
                din_im = -16'sh3c3c;
            end
        end
        check(first_dv == N + C + 1, "R4", "first dvalid clock", first_dv, N + C + 1);
        check(dv_count == N, "R4", "dvalid length", dv_count, N);
        check(ready_bad == 0, "R2", "ready high while busy", ready_bad, 0);
        check(ready_end == 1, "R6", "ready after burst", ready_end, 1);
    endtask

    task automatic check_bins(input string req);
        for (int k = 0; k < N; k++) begin
            real sr = 0.0, si = 0.0;
            int er, ei;
            for (int n = 0; n < N; n++) begin
                real a = TWO_PI * n * k / N;
                sr += in_re[n] * $cos(a) + in_im[n] * $sin(a);
                si += in_im[n] * $cos(a) - in_re[n] * $sin(a);
            end
            er = $rtoi(sr + (sr < 0 ? -0.5 : 0.5));
            ei = $rtoi(si + (si < 0 ? -0.5 : 0.5));
            check((out_re[k] - er <= TOL) && (er - out_re[k] <= TOL), req, "bin re", out_re[k], er);
            check((out_im[k] - ei <= TOL) && (ei - out_im[k] <= TOL), req, "bin im", out_im[k], ei);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
        check(dvalid == 1'b0, "R1", "dvalid after reset", int'(dvalid), 0);
    endtask

    task automatic t_impulse;
        for (int n = 0; n < N; n++) begin in_re[n] = 0; in_im[n] = 0; end
        in_re[0] = 1000; in_im[0] = -500;
        run_frame(1'b0);
        for (int k = 0; k < N; k++) begin
            check(out_re[k] == 1000, "R8", "impulse re", out_re[k], 1000);
            check(out_im[k] == -500, "R8", "impulse im", out_im[k], -500);
        end
    endtask

    task automatic t_shifted;
        for (int n = 0; n < N; n++) begin in_re[n] = 0; in_im[n] = 0; end
        in_re[3] = 2000; in_im[5] = -1500;
        run_frame(1'b0);
        check_bins("R3");
    endtask

    task automatic t_tone;
        for (int n = 0; n < N; n++) begin
            in_re[n] = $rtoi(3000.0 * $cos(TWO_PI * n / N));
            in_im[n] = $rtoi(3000.0 * $sin(TWO_PI * n / N));
        end
        run_frame(1'b0);
        check_bins("R5");
    endtask

    task automatic t_hold_start;
        for (int n = 0; n < N; n++) begin
            in_re[n] = (n * 733) % 3001 - 1500;
            in_im[n] = 1200 - (n * 419) % 2400;
        end
        run_frame(1'b1);
        check_bins("R2");
        @(negedge clk);
        check(ready == 1'b1, "R2", "no second frame", int'(ready), 1);
    endtask

    task automatic t_saturate;
        for (int n = 0; n < N; n++) begin in_re[n] = 30000; in_im[n] = -30000; end
        run_frame(1'b0);
        check(out_re[0] == 32767, "R7", "positive clamp", out_re[0], 32767);
        check(out_im[0] == -32768, "R7", "negative clamp", out_im[0], -32768);
    endtask

    initial begin
        t_reset();
        t_impulse();
        t_shifted();
        t_tone();
        t_hold_start();
        t_saturate();
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule